// File: doc/BRIEF.md
# Fractional Clock Divider with Swallow

This block turns a 24 MHz system clock into an average 1.8432 MHz rate, a ratio of 625 input cycles to 48 output periods. It produces a one-cycle tick, a square-wave clock and a marker at the end of each group of 48 output periods. A two-bit select picks how the rate is made. The dual-modulus mode runs 47 periods of 13 clocks and then one of 14. Its average is exact, and only that single stretched period moves an edge off the uniform grid. The phase-accumulator mode toggles the square wave whenever a phase register that grows by 96 each clock wraps past 625. The fixed mode divides by 13 every period, which gives no jitter and a small constant frequency error.

A converter front end or a serial clock generator uses the tick as a clock enable. The square wave can drive a pin. The mode is normally chosen once. If it is changed at run time, the change is applied only at a period boundary, so no period is ever cut short.

Top module: `frac_clk_div`

## Requirements
- R1: In the dual-modulus mode and in the accumulator mode, `tick` is high in exactly 48 of every 625 consecutive clock cycles, counted in windows that start at reset release.
- R2: In the dual-modulus mode (`mode_sel` = 0), periods are measured from tick to tick, and the first period starts at reset release. Every period is 13 or 14 clocks long. Within each group of 48 periods, the first 47 are 13 clocks and the 48th is 14 clocks.
- R3: `tick` is high for exactly one cycle per output period and is never high on two consecutive cycles.
- R4: In the counter modes, the cycle after a tick is cycle 0 of a new period. `clk_sq` is low for cycles 0 to 5 of each period and high from cycle 6 up to and including the tick cycle.
- R5: `frame` is high only together with the tick that ends the 14-clock period, so it pulses once per 48 periods. It is only high in the dual-modulus mode and is never high without `tick`.
- R6: In the accumulator mode (`mode_sel` = 1), a phase value starts at 0 and gains 96 modulo 625 on each clock. `clk_sq` toggles on the cycle after each cycle in which the phase wraps. `tick` is high on a wrap cycle when `clk_sq` is high.
- R7: In the fixed mode (`mode_sel` = 2 or 3), every period is exactly 13 clocks and `frame` stays low.
- R8: The mode codes are 0 for dual-modulus, 1 for accumulator, and 2 or 3 for fixed. `mode_sel` is sampled only on tick cycles and during reset. A new code applies from the period after the tick, and that period starts with its counters at zero.
- R9: While `rst` is high at a clock edge, the counters, the group index, the phase and `clk_sq` are cleared and `mode_sel` is captured. After release, the first tick of a counter mode comes on cycle 12, and the accumulator mode restarts its phase at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (24 MHz in the target use) |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Division mode: 0 dual-modulus, 1 accumulator, 2 or 3 fixed |
| tick | output | 1 | One-cycle pulse marking the end of each output period |
| clk_sq | output | 1 | Square-wave output clock |
| frame | output | 1 | Pulse with the tick that ends each 48-period group |

## Verification
`tick` and `frame` are decoded directly from registered state, so they are due in the same cycle the period count reaches its last value. `clk_sq` is a register, so it changes one cycle after the half-period count, the tick, or the phase wrap that causes the change. A mode code is taken at the tick edge and governs the next cycle onward, and reset shows its effect after one edge. The bench drives inputs and reads outputs on the falling edge. It numbers cycles from reset release, and it predicts each tick, square-wave level and frame from those cycle counts or from its own phase arithmetic. It then compares every sampled cycle against the prediction.

// File: rtl/frac_div_pkg.sv
`timescale 1ns/1ps
package frac_div_pkg;

   typedef enum logic [1:0] {
      MODE_SWALLOW  = 2'd0,
      MODE_ACCUM    = 2'd1,
      MODE_FIXED    = 2'd2,
      MODE_FIXED_B  = 2'd3
   } div_mode_e;

endpackage

// File: rtl/frac_mode_ctl.sv
`timescale 1ns/1ps
module frac_mode_ctl
   import frac_div_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic [1:0] mode_sel,
   output logic [1:0] mode_q,
   output logic       restart,
   output logic       acc_mode,
   output logic       swallow_mode
);

   // the mode is taken in reset and at period boundaries only
   always_ff @(posedge clk) begin
      if (rst || tick) begin
         mode_q <= mode_sel;
      end
   end

   always_comb begin
      restart      = tick && (mode_sel != mode_q);
      acc_mode     = (mode_q == MODE_ACCUM);
      swallow_mode = (mode_q == MODE_SWALLOW);
   end

endmodule

// File: rtl/frac_swallow_core.sv
`timescale 1ns/1ps
module frac_swallow_core #(
   parameter int BASE     = 13,
   parameter int DEN      = 48,
   parameter int LONG_CNT = 1,
   parameter int HALF     = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic swallow,
   input  logic restart,
   output logic tick_o,
   output logic half_o,
   output logic last_o
);

   localparam int CNT_W  = $clog2(BASE + 2);
   localparam int PIDX_W = $clog2(DEN);

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  len_m1;
   logic [PIDX_W-1:0] pidx;
   logic              is_long;

   // the stretched periods sit at the end of each group
   generate
      if (LONG_CNT == 0) begin : g_no_long
         assign is_long = 1'b0;
      end else begin : g_long
         assign is_long = swallow && (pidx >= PIDX_W'(DEN - LONG_CNT));
      end
   endgenerate

   always_comb begin
      len_m1 = is_long ? CNT_W'(BASE) : CNT_W'(BASE - 1);
      tick_o = run && (cnt == len_m1);
      half_o = run && (cnt == CNT_W'(HALF - 1));
      last_o = tick_o && swallow && (pidx == PIDX_W'(DEN - 1));
   end

   always_ff @(posedge clk) begin
      if (rst || restart || !run) begin
         cnt  <= '0;
         pidx <= '0;
      end else if (tick_o) begin
         cnt <= '0;
         if (!swallow || (pidx == PIDX_W'(DEN - 1))) begin
            pidx <= '0;
         end else begin
            pidx <= pidx + 1'b1;
         end
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/frac_accum_core.sv
`timescale 1ns/1ps
module frac_accum_core #(
   parameter int NUM  = 625,
   parameter int STEP = 96
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic restart,
   output logic wrap_o
);

   localparam int ACC_W = $clog2(NUM + STEP);

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] sum;

   always_comb begin
      sum    = acc + ACC_W'(STEP);
      wrap_o = run && (sum >= ACC_W'(NUM));
   end

   always_ff @(posedge clk) begin
      if (rst || restart || !run) begin
         acc <= '0;
      end else if (wrap_o) begin
         acc <= sum - ACC_W'(NUM);
      end else begin
         acc <= sum;
      end
   end

endmodule

// File: rtl/frac_clk_div.sv
`timescale 1ns/1ps
module frac_clk_div #(
   parameter int NUM = 625,
   parameter int DEN = 48
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] mode_sel,
   output logic       tick,
   output logic       clk_sq,
   output logic       frame
);

   localparam int BASE     = NUM / DEN;
   localparam int LONG_CNT = NUM % DEN;
   localparam int STEP     = 2 * DEN;
   localparam int HALF     = BASE / 2;

   generate
      if (DEN < 2) begin : g_bad_den
         $error("frac_clk_div: DEN must be at least 2");
      end
      if (BASE < 4) begin : g_bad_base
         $error("frac_clk_div: NUM/DEN must be at least 4");
      end
      if (STEP >= NUM) begin : g_bad_step
         $error("frac_clk_div: 2*DEN must be below NUM");
      end
   endgenerate

   logic [1:0] mode_q;
   logic       restart;
   logic       acc_mode;
   logic       swallow_mode;
   logic       cnt_tick;
   logic       cnt_half;
   logic       cnt_last;
   logic       acc_wrap;
   logic       sq_q;

   frac_mode_ctl u_mode (
      .clk          (clk),
      .rst          (rst),
      .tick         (tick),
      .mode_sel     (mode_sel),
      .mode_q       (mode_q),
      .restart      (restart),
      .acc_mode     (acc_mode),
      .swallow_mode (swallow_mode)
   );

   frac_swallow_core #(
      .BASE     (BASE),
      .DEN      (DEN),
      .LONG_CNT (LONG_CNT),
      .HALF     (HALF)
   ) u_swallow (
      .clk     (clk),
      .rst     (rst),
      .run     (!acc_mode),
      .swallow (swallow_mode),
      .restart (restart),
      .tick_o  (cnt_tick),
      .half_o  (cnt_half),
      .last_o  (cnt_last)
   );

   frac_accum_core #(
      .NUM  (NUM),
      .STEP (STEP)
   ) u_accum (
      .clk     (clk),
      .rst     (rst),
      .run     (acc_mode),
      .restart (restart),
      .wrap_o  (acc_wrap)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sq_q <= 1'b0;
      end else if (acc_mode) begin
         if (acc_wrap) begin
            sq_q <= ~sq_q;
         end
      end else if (cnt_tick) begin
         sq_q <= 1'b0;
      end else if (cnt_half) begin
         sq_q <= 1'b1;
      end
   end

   always_comb begin
      tick   = acc_mode ? (acc_wrap && sq_q) : cnt_tick;
      clk_sq = sq_q;
      frame  = cnt_last;
   end

endmodule

// File: rtl/frac_clk_div_chk.sv
`timescale 1ns/1ps
module frac_clk_div_chk #(
   parameter int BASE = 13
) (
   input logic       clk,
   input logic       rst,
   input logic       tick,
   input logic       clk_sq,
   input logic       frame,
   input logic [1:0] mode_q
);

   localparam int GAP_W = $clog2(4 * BASE + 1);

   logic [GAP_W-1:0] gap;

   always_ff @(posedge clk) begin
      if (rst || tick) begin
         gap <= '0;
      end else if (gap != '1) begin
         gap <= gap + 1'b1;
      end
   end

   assert_swallow_len_R2: assert property (@(posedge clk) disable iff (rst)
      (tick && mode_q == 2'd0) |-> (gap == GAP_W'(BASE - 1) || gap == GAP_W'(BASE)));

   assert_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);

   assert_tick_high_R4: assert property (@(posedge clk) disable iff (rst)
      tick |-> clk_sq);

   assert_sq_low_after_tick_R4: assert property (@(posedge clk) disable iff (rst)
      tick |=> !clk_sq);

   assert_frame_with_tick_R5: assert property (@(posedge clk) disable iff (rst)
      frame |-> (tick && mode_q == 2'd0));

   assert_fixed_len_R7: assert property (@(posedge clk) disable iff (rst)
      (tick && mode_q[1]) |-> (gap == GAP_W'(BASE - 1)));

   assert_mode_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$stable(mode_q)) |-> $past(tick));

   assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> (!tick && !clk_sq && !frame));

endmodule

bind frac_clk_div frac_clk_div_chk #(.BASE(BASE)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .tick   (tick),
   .clk_sq (clk_sq),
   .frame  (frame),
   .mode_q (mode_q)
);

// File: tb/frac_clk_div_tb.sv
`timescale 1ns/1ps
module frac_clk_div_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] mode_sel = 2'd0;
   logic       tick;
   logic       clk_sq;
   logic       frame;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   frac_clk_div u_dut (
      .clk      (clk),
      .rst      (rst),
      .mode_sel (mode_sel),
      .tick     (tick),
      .clk_sq   (clk_sq),
      .frame    (frame)
   );

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // reset with a mode; returns at the falling edge where cycle 0 is visible
   task automatic start(input logic [1:0] m);
      @(negedge clk);
      rst = 1'b1;
      mode_sel = m;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   // one accumulator-mode cycle against the phase arithmetic
   task automatic acc_step(inout int acc, inout bit sq_m, inout int mism, inout int ticks);
      bit wrap;
      bit et;
      wrap = (acc + 96) >= 625;
      et   = wrap && sq_m;
      if (tick !== et) mism++;
      if (clk_sq !== sq_m) mism++;
      if (et) ticks++;
      if (wrap) begin
         sq_m = !sq_m;
         acc  = acc + 96 - 625;
      end else begin
         acc = acc + 96;
      end
      @(negedge clk);
   endtask

   task automatic t_reset();
      int first;
      start(2'd0);
      check_eq("R9", "tick right after reset", int'(tick), 0);
      check_eq("R9", "clk_sq right after reset", int'(clk_sq), 0);
      repeat (19) @(negedge clk);
      check_eq("R4", "clk_sq in cycle 6 of second period", int'(clk_sq), 1);
      rst = 1'b1;
      @(negedge clk);
      check_eq("R9", "outputs low after mid-run reset",
               int'({tick, clk_sq, frame}), 0);
      rst = 1'b0;
      first = -1;
      for (int s = 0; s < 30; s++) begin
         if (tick && first < 0) first = s;
         @(negedge clk);
      end
      check_eq("R9", "first tick cycle after reset", first, 12);
   endtask

   task automatic t_accum_reset();
      int acc = 0;
      bit sq_m = 1'b0;
      int mism = 0;
      int ticks = 0;
      start(2'd1);
      repeat (37) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int s = 0; s < 200; s++) acc_step(acc, sq_m, mism, ticks);
      check_eq("R9", "accumulator restart from zero phase", mism, 0);
   endtask

   task automatic t_swallow();
      int last = -1;
      int ticks = 0;
      int bad_len = 0;
      int longs = 0;
      int long_idx = -1;
      int frames = 0;
      int bad_frame = 0;
      int sq_bad = 0;
      int dbl = 0;
      bit prev = 1'b0;
      start(2'd0);
      for (int s = 0; s < 625; s++) begin
         int c = s - last - 1;
         if (clk_sq !== (c >= 6)) sq_bad++;
         if (frame && !tick) bad_frame++;
         if (prev && tick) dbl++;
         prev = tick;
         if (tick) begin
            int len = s - last;
            if (len != 13 && len != 14) bad_len++;
            if (len == 14) begin
               longs++;
               long_idx = ticks;
            end
            if (frame) begin
               frames++;
               if (len != 14) bad_frame++;
            end
            ticks++;
            last = s;
         end
         @(negedge clk);
      end
      check_eq("R1", "ticks in 625 cycles, dual-modulus", ticks, 48);
      check_eq("R1", "cycle of 48th tick", last, 624);
      check_eq("R2", "periods not 13 or 14", bad_len, 0);
      check_eq("R2", "14-clock periods per group", longs, 1);
      check_eq("R2", "index of 14-clock period", long_idx, 47);
      check_eq("R3", "consecutive tick cycles", dbl, 0);
      check_eq("R4", "clk_sq level mismatches", sq_bad, 0);
      check_eq("R5", "frame pulses per group", frames, 1);
      check_eq("R5", "misplaced frame pulses", bad_frame, 0);
   endtask

   task automatic t_accum();
      int acc = 0;
      bit sq_m = 1'b0;
      int mism = 0;
      int w0 = 0;
      int w1 = 0;
      int fr = 0;
      start(2'd1);
      for (int s = 0; s < 1250; s++) begin
         if (frame) fr++;
         if (s < 625) acc_step(acc, sq_m, mism, w0);
         else acc_step(acc, sq_m, mism, w1);
      end
      check_eq("R6", "tick/clk_sq mismatches vs phase arithmetic", mism, 0);
      check_eq("R1", "ticks in first 625 cycles, accumulator", w0, 48);
      check_eq("R1", "ticks in second 625 cycles, accumulator", w1, 48);
      check_eq("R5", "frame pulses in accumulator mode", fr, 0);
   endtask

   task automatic t_fixed(input logic [1:0] m);
      int last = -1;
      int ticks = 0;
      int bad_len = 0;
      int fr = 0;
      int sq_bad = 0;
      start(m);
      for (int s = 0; s < 650; s++) begin
         int c = s - last - 1;
         if (clk_sq !== (c >= 6)) sq_bad++;
         if (frame) fr++;
         if (tick) begin
            if (s - last != 13) bad_len++;
            ticks++;
            last = s;
         end
         @(negedge clk);
      end
      check_eq("R7", $sformatf("ticks in 650 cycles, code %0d", m), ticks, 50);
      check_eq("R7", $sformatf("periods not 13, code %0d", m), bad_len, 0);
      check_eq("R7", $sformatf("frame pulses, code %0d", m), fr, 0);
      check_eq("R4", $sformatf("clk_sq mismatches, code %0d", m), sq_bad, 0);
   endtask

   task automatic t_switch();
      int s = 0;
      int last = -1;
      int nt = 0;
      int acc = 0;
      bit sq_m = 1'b0;
      int mism = 0;
      int mt = 0;
      int t0;
      start(2'd0);
      while (nt < 3) begin
         if (tick) begin
            nt++;
            last = s;
         end
         @(negedge clk);
         s++;
      end
      check_eq("R2", "cycle of third tick", last, 38);
      repeat (3) begin
         @(negedge clk);
         s++;
      end
      mode_sel = 2'd1;
      while (!tick) begin
         @(negedge clk);
         s++;
      end
      check_eq("R8", "period length while change pending", s - last, 13);
      @(negedge clk);
      while (mt < 10) acc_step(acc, sq_m, mism, mt);
      repeat (2) acc_step(acc, sq_m, mism, mt);
      mode_sel = 2'd2;
      while (mt < 11) acc_step(acc, sq_m, mism, mt);
      check_eq("R8", "accumulator run after switch from zero phase", mism, 0);
      t0 = 0;
      while (!tick) begin
         @(negedge clk);
         t0++;
      end
      check_eq("R8", "first fixed period after switch", t0 + 1, 13);
      @(negedge clk);
      t0 = 0;
      while (!tick) begin
         @(negedge clk);
         t0++;
      end
      check_eq("R8", "second fixed period after switch", t0 + 1, 13);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual hung expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_accum_reset();
      t_swallow();
      t_accum();
      t_fixed(2'd2);
      t_fixed(2'd3);
      t_switch();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule